// File: doc/BRIEF.md
# Triggered Burst DMA Channel

A single-channel copy engine that moves samples from a small block of source registers into a RAM buffer without processor involvement. Software-facing setup is presented as static configuration inputs: a words-per-burst field and a bursts-per-transfer field (both stored as count minus one), a source base with a signed per-word step, a destination base, a 16/32-bit width select and a continuous-mode select. A `start` pulse arms the channel. Each rising `trigger` (for example a conversion-complete strobe from a converter) then runs exactly one burst. After the final burst of the transfer, the channel pulses `doneIrq` and either goes idle or rearms itself.

Each burst spends one lead-in cycle and then four cycles per word: read, capture, write, step. The source pointer returns to its base at every burst, so the same register window is sampled each time. The destination pointer keeps advancing from one burst to the next, which lays the samples out in the buffer in the order they were taken. The channel shares one memory port with a CPU port. When both ask for the port in the same cycle, the channel wins and the CPU is held off.

Top module: `trig_burst_dma`

## Requirements
- R1: During and straight after reset, `busy`, `doneIrq`, `overrun`, `memReq` (with no CPU request) and `cpuGrant` are all low.
- R2: A trigger sampled while armed makes `busy` high from the next cycle for exactly 1 + 4·N cycles, where N = `cfgBurstWords` + 1 (range 1 to 32).
- R3: In a narrow (16-bit) burst, word k is read at its source address in cycle 1 + 4k of the burst. It is written to its destination address in cycle 3 + 4k, and the written value equals the value read.
- R4: The source address of word k is `cfgSrcBase` + k·`cfgSrcStep`. The step is a signed two's-complement value. The address restarts at the base on every burst.
- R5: The destination address advances by 1 per word in 16-bit mode and by 2 per word in 32-bit mode, and it carries on from burst to burst. `start` reloads it from `cfgDstBase`.
- R6: With `cfgWide` = 1, every channel access drives `memWide` high and moves 32 bits. The lower half goes to the even (first) address and the upper half to the address after it.
- R7: At the end of burst `cfgBurstCount` + 1, `doneIrq` is high for exactly one cycle, the cycle after `busy` falls. With `cfgContinuous` = 0 the channel is then idle, and later triggers start nothing.
- R8: With `cfgContinuous` = 1, completion rearms the channel, reloads the burst count and reloads the destination from `cfgDstBase`.
- R9: A trigger seen while `busy` is high sets the sticky `overrun` flag, and no extra burst follows from it. Only an accepted `start` clears `overrun`.
- R10: `cpuGrant` equals `cpuReq` in every cycle in which the channel does not access memory. It is low in the cycles in which the channel does access memory, and the port then carries the channel's address.
- R11: A trigger while idle (never started, or stopped after completion) has no effect on `busy` or `memReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm pulse; loads counters and destination, clears overrun |
| trigger | input | 1 | Peripheral event; one burst per pulse |
| cfgBurstWords | input | 5 | Words per burst minus one |
| cfgBurstCount | input | 16 | Bursts per transfer minus one |
| cfgSrcBase | input | 16 | Source window base address |
| cfgSrcStep | input | 8 | Signed source step per word |
| cfgDstBase | input | 16 | Destination buffer base |
| cfgWide | input | 1 | 1 = 32-bit moves, 0 = 16-bit |
| cfgContinuous | input | 1 | Rearm after completion |
| cpuReq | input | 1 | CPU memory request |
| cpuWe | input | 1 | CPU write enable |
| cpuAddr | input | 16 | CPU address |
| cpuWdata | input | 32 | CPU write data |
| cpuGrant | output | 1 | CPU request granted this cycle |
| memReq | output | 1 | Memory port request |
| memWe | output | 1 | Memory port write enable |
| memWide | output | 1 | 32-bit access |
| memAddr | output | 16 | Memory port address |
| memWdata | output | 32 | Memory port write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | A burst is in progress |
| doneIrq | output | 1 | Transfer-complete pulse |
| overrun | output | 1 | Sticky trigger-overrun flag |

## Verification
A trigger driven before an edge puts `busy` high in the next cycle, and `busy` then stays high for 1 + 4N cycles. Inside that window, offset e ≥ 1 is phase (e−1) mod 4 of word (e−1)/4. The read address is due at phase 0 and the write address at phase 2. `doneIrq` is due one cycle after the last step phase. The bench's behavioural model counts down those same windows from the trigger edge. It derives the expected port address, `busy`, `doneIrq`, `overrun` and `cpuGrant` for every cycle. All outputs are compared at the falling edge, halfway between the edges that change them. The buffer contents are compared against the model's image once each burst has fully drained.

// File: rtl/trig_dma_pkg.sv
package trig_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_LEAD,
    ST_MOVE
  } dmaState_t;

  typedef enum logic [1:0] {
    PH_READ,
    PH_HOLD,
    PH_WRITE,
    PH_STEP
  } wordPhase_t;

  // strobes from the sequencer to the address/data path
  typedef struct packed {
    logic loadBase;    // arm: destination from base
    logic burstStart;  // lead-in cycle: source back to base
    logic capture;     // latch read data
    logic stepWord;    // advance both pointers
    logic reloadDst;   // continuous completion: destination from base
  } pathCtl_t;

endpackage

// File: rtl/trig_dma_ctrl.sv
module trig_dma_ctrl
  import trig_dma_pkg::*;
#(
  parameter int BURST_W = 5,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               trigger,
  input  logic [BURST_W-1:0] cfgBurstWords,
  input  logic [COUNT_W-1:0] cfgBurstCount,
  input  logic               cfgContinuous,
  output pathCtl_t           ctl,
  output logic               dmaRead,
  output logic               dmaWrite,
  output logic               busy,
  output logic               doneIrq,
  output logic               overrun
);

  dmaState_t          state;
  wordPhase_t         phase;
  logic [BURST_W-1:0] wordsLeft;
  logic [COUNT_W-1:0] burstsLeft;

  logic startAccept;
  logic lastWord;
  logic lastBurst;
  logic stepPhase;

  assign startAccept = start && (state == ST_IDLE || state == ST_ARMED);
  assign lastWord    = (wordsLeft == '0);
  assign lastBurst   = (burstsLeft == '0);
  assign stepPhase   = (state == ST_MOVE) && (phase == PH_STEP);

  assign busy     = (state == ST_LEAD) || (state == ST_MOVE);
  assign dmaRead  = (state == ST_MOVE) && (phase == PH_READ);
  assign dmaWrite = (state == ST_MOVE) && (phase == PH_WRITE);

  always_comb begin
    ctl            = '0;
    ctl.loadBase   = startAccept;
    ctl.burstStart = (state == ST_LEAD);
    ctl.capture    = (state == ST_MOVE) && (phase == PH_HOLD);
    ctl.stepWord   = stepPhase;
    ctl.reloadDst  = stepPhase && lastWord && lastBurst && cfgContinuous;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      phase      <= PH_READ;
      wordsLeft  <= '0;
      burstsLeft <= '0;
      doneIrq    <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      doneIrq <= 1'b0;
      if (trigger && busy) begin
        overrun <= 1'b1;
      end else if (startAccept) begin
        overrun <= 1'b0;
      end
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            burstsLeft <= cfgBurstCount;
            state      <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (start) begin
            burstsLeft <= cfgBurstCount;
          end else if (trigger) begin
            state <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          wordsLeft <= cfgBurstWords;
          phase     <= PH_READ;
          state     <= ST_MOVE;
        end
        ST_MOVE: begin
          phase <= wordPhase_t'(phase + 2'd1);
          if (phase == PH_STEP) begin
            if (!lastWord) begin
              wordsLeft <= wordsLeft - 1'b1;
            end else if (lastBurst) begin
              doneIrq    <= 1'b1;
              burstsLeft <= cfgBurstCount;
              state      <= cfgContinuous ? ST_ARMED : ST_IDLE;
            end else begin
              burstsLeft <= burstsLeft - 1'b1;
              state      <= ST_ARMED;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R9
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !startAccept) |=> overrun);

  // R2
  busy_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trigger));

  // R11
  idle_ignores_trigger_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !start) |=> !busy);

  // R3
  port_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaRead || dmaWrite) |=> !(dmaRead || dmaWrite));

endmodule

// File: rtl/trig_dma_path.sv
module trig_dma_path
  import trig_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int STEP_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [ADDR_W-1:0] cfgSrcBase,
  input  logic [STEP_W-1:0] cfgSrcStep,
  input  logic [ADDR_W-1:0] cfgDstBase,
  input  logic              cfgWide,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [DATA_W-1:0] holdData
);

  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] stepExt;
  logic [ADDR_W-1:0] dstInc;

  assign stepExt = {{(ADDR_W-STEP_W){cfgSrcStep[STEP_W-1]}}, cfgSrcStep};
  assign dstInc  = cfgWide ? ADDR_W'(2) : ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      holdData <= '0;
    end else begin
      if (ctl.burstStart) begin
        srcAddr <= cfgSrcBase;
      end else if (ctl.stepWord) begin
        srcAddr <= srcAddr + stepExt;
      end
      if (ctl.loadBase || ctl.reloadDst) begin
        dstAddr <= cfgDstBase;
      end else if (ctl.stepWord) begin
        dstAddr <= dstAddr + dstInc;
      end
      if (ctl.capture) begin
        holdData <= cfgWide ? memRdata : {{HALF_W{1'b0}}, memRdata[HALF_W-1:0]};
      end
    end
  end

  // R5
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.loadBase || ctl.reloadDst || ctl.stepWord) |=> $stable(dstAddr));

endmodule

// File: rtl/trig_burst_dma.sv
module trig_burst_dma
  import trig_dma_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int STEP_W  = 8,
  parameter int DATA_W  = 32,
  parameter int BURST_W = 5,
  parameter int COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               trigger,
  input  logic [BURST_W-1:0] cfgBurstWords,
  input  logic [COUNT_W-1:0] cfgBurstCount,
  input  logic [ADDR_W-1:0]  cfgSrcBase,
  input  logic [STEP_W-1:0]  cfgSrcStep,
  input  logic [ADDR_W-1:0]  cfgDstBase,
  input  logic               cfgWide,
  input  logic               cfgContinuous,
  input  logic               cpuReq,
  input  logic               cpuWe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic               cpuGrant,
  output logic               memReq,
  output logic               memWe,
  output logic               memWide,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  input  logic [DATA_W-1:0]  memRdata,
  output logic               busy,
  output logic               doneIrq,
  output logic               overrun
);

  pathCtl_t          ctl;
  logic              dmaRead;
  logic              dmaWrite;
  logic              dmaReq;
  logic [ADDR_W-1:0] srcAddr;
  logic [ADDR_W-1:0] dstAddr;
  logic [DATA_W-1:0] holdData;

  trig_dma_ctrl #(
    .BURST_W(BURST_W),
    .COUNT_W(COUNT_W)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .trigger      (trigger),
    .cfgBurstWords(cfgBurstWords),
    .cfgBurstCount(cfgBurstCount),
    .cfgContinuous(cfgContinuous),
    .ctl          (ctl),
    .dmaRead      (dmaRead),
    .dmaWrite     (dmaWrite),
    .busy         (busy),
    .doneIrq      (doneIrq),
    .overrun      (overrun)
  );

  trig_dma_path #(
    .ADDR_W(ADDR_W),
    .STEP_W(STEP_W),
    .DATA_W(DATA_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cfgSrcBase(cfgSrcBase),
    .cfgSrcStep(cfgSrcStep),
    .cfgDstBase(cfgDstBase),
    .cfgWide   (cfgWide),
    .memRdata  (memRdata),
    .srcAddr   (srcAddr),
    .dstAddr   (dstAddr),
    .holdData  (holdData)
  );

  // port arbitration: the channel always wins
  assign dmaReq   = dmaRead || dmaWrite;
  assign cpuGrant = cpuReq && !dmaReq;
  assign memReq   = dmaReq || cpuReq;
  assign memWe    = dmaReq ? dmaWrite : cpuWe;
  assign memWide  = dmaReq && cfgWide;
  assign memWdata = dmaReq ? holdData : cpuWdata;

  always_comb begin
    if (dmaRead) begin
      memAddr = srcAddr;
    end else if (dmaWrite) begin
      memAddr = dstAddr;
    end else begin
      memAddr = cpuAddr;
    end
  end

  // R10
  cpu_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuGrant |-> !(dmaRead || dmaWrite));

endmodule

// File: tb/trig_burst_dma_tb.sv
module trig_burst_dma_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        trigger = 1'b0;
  logic [4:0]  cfgBurstWords = '0;
  logic [15:0] cfgBurstCount = '0;
  logic [15:0] cfgSrcBase = '0;
  logic [7:0]  cfgSrcStep = 8'd1;
  logic [15:0] cfgDstBase = '0;
  logic        cfgWide = 1'b0;
  logic        cfgContinuous = 1'b0;
  logic        cpuReq = 1'b0;
  logic        cpuWe = 1'b0;
  logic [15:0] cpuAddr = 16'd250;
  logic [31:0] cpuWdata = '0;
  logic        cpuGrant;
  logic        memReq;
  logic        memWe;
  logic        memWide;
  logic [15:0] memAddr;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic        busy;
  logic        doneIrq;
  logic        overrun;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem [256];
  logic [15:0] expImg [256];
  bit          expUse [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_burst_dma u_dut (
    .clk(clk), .rstN(rstN), .start(start), .trigger(trigger),
    .cfgBurstWords(cfgBurstWords), .cfgBurstCount(cfgBurstCount),
    .cfgSrcBase(cfgSrcBase), .cfgSrcStep(cfgSrcStep), .cfgDstBase(cfgDstBase),
    .cfgWide(cfgWide), .cfgContinuous(cfgContinuous),
    .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .cpuGrant(cpuGrant), .memReq(memReq), .memWe(memWe), .memWide(memWide),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .doneIrq(doneIrq), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", what, act, exp, $time);
    end
  endtask

  // memory behind the port: read data is due the cycle after the request
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        mem[memAddr[7:0]] <= memWdata[15:0];
        if (memWide) mem[8'(memAddr[7:0] + 8'd1)] <= memWdata[31:16];
      end else begin
        memRdata <= memWide ? {mem[8'(memAddr[7:0] + 8'd1)], mem[memAddr[7:0]]}
                            : {16'h0, mem[memAddr[7:0]]};
      end
    end
  end

  // CPU traffic from a small LFSR
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cpuReq <= rstN && lfsr[0] && lfsr[2];
  end

  // behavioural model, advanced on each rising edge
  int          mBusyLeft = 0;
  int          mTotal = 0;
  int          mWords = 0;
  int          mBurstsLeft = 0;
  bit          mArmed = 0;
  bit          mOverrun = 0;
  bit          mIrq = 0;
  logic [15:0] mBurstDst = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusyLeft = 0; mArmed = 0; mOverrun = 0; mIrq = 0; mBurstsLeft = 0;
    end else begin
      mIrq = 0;
      if (mBusyLeft > 0) begin
        if (trigger) mOverrun = 1;
        mBusyLeft--;
        if (mBusyLeft == 0) begin
          mBurstDst = mBurstDst + 16'(mWords * (cfgWide ? 2 : 1));
          if (mBurstsLeft == 0) begin
            mIrq = 1;
            mBurstsLeft = int'(cfgBurstCount);
            mArmed = cfgContinuous;
            if (cfgContinuous) mBurstDst = cfgDstBase;
          end else begin
            mBurstsLeft--;
            mArmed = 1;
          end
        end
      end else if (start) begin
        mArmed = 1; mOverrun = 0;
        mBurstsLeft = int'(cfgBurstCount);
        mBurstDst = cfgDstBase;
      end else if (mArmed && trigger) begin
        mWords = int'(cfgBurstWords) + 1;
        mTotal = 1 + 4 * mWords;
        mBusyLeft = mTotal;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      int e, ph, k;
      bit acc;
      logic [15:0] expA;
      e   = mTotal - mBusyLeft;
      acc = 0;
      ph  = 0;
      k   = 0;
      if (mBusyLeft > 0 && e >= 1) begin
        ph  = (e - 1) % 4;
        k   = (e - 1) / 4;
        acc = (ph == 0 || ph == 2);
      end
      chk(busy == (mBusyLeft > 0), "R2 busy window", busy, mBusyLeft > 0);
      chk(doneIrq == mIrq, "R7 completion pulse", doneIrq, mIrq);
      chk(overrun == mOverrun, "R9 overrun flag", overrun, mOverrun);
      chk(cpuGrant == (cpuReq && !acc), "R10 cpu grant", cpuGrant, cpuReq && !acc);
      if (acc) begin
        if (ph == 0) expA = cfgSrcBase + 16'(k) * {{8{cfgSrcStep[7]}}, cfgSrcStep};
        else         expA = mBurstDst + 16'(k * (cfgWide ? 2 : 1));
        chk(memReq == 1'b1, "R3 channel request", memReq, 1);
        chk(memWe == (ph == 2), "R3 read/write order", memWe, ph == 2);
        chk(memAddr == expA, ph == 0 ? "R4 source address" : "R5 destination address",
            memAddr, expA);
        chk(memWide == cfgWide, "R6 access width", memWide, cfgWide);
      end else if (mBusyLeft == 0 && !cpuReq) begin
        chk(memReq == 1'b0, "R11 no idle access", memReq, 0);
      end
    end
  end

  function automatic logic [15:0] srcVal(input int tid, input int b, input logic [15:0] a);
    return 16'((tid << 12) | ((b & 15) << 8) | int'(a[7:0]));
  endfunction

  task automatic pulseStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic pulseTrigger();
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
  endtask

  // one burst: load the source window, register the expected image, trigger, drain
  task automatic doBurst(input int tid, input int b, input int nBursts, input int extraAt);
    int words, inc;
    logic [15:0] a, d, stepExt;
    words   = int'(cfgBurstWords) + 1;
    inc     = cfgWide ? 2 : 1;
    stepExt = {{8{cfgSrcStep[7]}}, cfgSrcStep};
    for (int k = 0; k < words; k++) begin
      a = cfgSrcBase + 16'(k) * stepExt;
      d = cfgDstBase + 16'(((b % nBursts) * words + k) * inc);
      mem[a[7:0]] = srcVal(tid, b, a);
      expImg[d[7:0]] = srcVal(tid, b, a);
      expUse[d[7:0]] = 1;
      mem[d[7:0]] = 16'hDEAD;
      if (cfgWide) begin
        mem[8'(a[7:0] + 8'd1)] = srcVal(tid, b, a + 16'd1);
        expImg[8'(d[7:0] + 8'd1)] = srcVal(tid, b, a + 16'd1);
        expUse[8'(d[7:0] + 8'd1)] = 1;
        mem[8'(d[7:0] + 8'd1)] = 16'hDEAD;
      end
    end
    pulseTrigger();
    for (int c = 1; c < 4 * words + 4; c++) begin
      if (c == extraAt) pulseTrigger();
      else @(negedge clk);
    end
  endtask

  task automatic checkImage(input string what);
    for (int i = 0; i < 256; i++) begin
      if (expUse[i]) begin
        chk(mem[i] == expImg[i], what, mem[i], expImg[i]);
        expUse[i] = 0;
      end
    end
  endtask

  task automatic setCfg(input int words, input int bursts, input int sb, input int st,
                        input int db, input bit wide, input bit cont);
    cfgBurstWords = 5'(words - 1);
    cfgBurstCount = 16'(bursts - 1);
    cfgSrcBase    = 16'(sb);
    cfgSrcStep    = 8'(st);
    cfgDstBase    = 16'(db);
    cfgWide       = wide;
    cfgContinuous = cont;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'(i); expUse[i] = 0; expImg[i] = '0; end
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!busy && !doneIrq && !overrun, "R1 reset outputs", {busy, doneIrq, overrun}, 0);
    chk(!memReq && !cpuGrant, "R1 reset port", {memReq, cpuGrant}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !doneIrq && !overrun, "R1 after reset", {busy, doneIrq, overrun}, 0);

    // R11: trigger before any start is ignored
    pulseTrigger();
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R11 trigger while idle", busy, 0);

    // R2 R3 R4 R5: narrow, 6 words x 3 bursts
    setCfg(6, 3, 16, 1, 100, 0, 0);
    pulseStart();
    for (int b = 0; b < 3; b++) begin
      doBurst(1, b, 3, 0);
      repeat (3) @(negedge clk);
    end
    checkImage("R3 narrow buffer contents");

    // R7: trigger after completion in single mode does nothing
    pulseTrigger();
    repeat (6) @(negedge clk);
    chk(busy == 1'b0, "R7 stopped after completion", busy, 0);

    // R4: negative step, 4 words, one burst
    setCfg(4, 1, 40, -1, 120, 0, 0);
    pulseStart();
    doBurst(2, 0, 1, 0);
    checkImage("R4 negative step contents");

    // R9: second trigger mid-burst sets overrun, no extra burst
    setCfg(2, 1, 50, 1, 140, 0, 0);
    pulseStart();
    doBurst(3, 0, 1, 3);
    repeat (8) @(negedge clk);
    chk(overrun == 1'b1, "R9 overrun sticky", overrun, 1);
    chk(busy == 1'b0, "R9 overrun not queued", busy, 0);
    checkImage("R9 buffer after overrun");
    pulseStart();
    chk(overrun == 1'b0, "R9 start clears overrun", overrun, 0);

    // R6 R8: wide moves, 2 words x 2 bursts, continuous, third burst wraps to base
    setCfg(2, 2, 8, 2, 160, 1, 1);
    pulseStart();
    for (int b = 0; b < 3; b++) begin
      doBurst(4, b, 2, 0);
      repeat (2) @(negedge clk);
    end
    checkImage("R8 continuous rearm contents");

    // R2: longest burst, 32 words
    setCfg(32, 1, 0, 1, 60, 0, 0);
    pulseStart();
    doBurst(5, 0, 1, 0);
    repeat (3) @(negedge clk);
    checkImage("R2 32-word burst contents");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule